// File: doc/BRIEF.md
# I2C Direction-Tracking Bus Repeater

This block joins two I2C segments that have no direct copper between them: one segment carries a single master, the other a single slave. Two open-drain lines cannot simply follow each other. A low on one side would be driven onto the other side, read back, and driven onto the first side again, so both lines would stay low for good. The block avoids this by following the protocol. It samples master SCL and both SDA lines with a system clock many times faster than SCL. It finds START and STOP, counts the bits of each byte, and latches the read/write bit of the address byte. From that position it picks exactly one side as the owner of SDA for each bit.

The owner's synchronised SDA level is copied to the other side as it arrives, bit by bit, with only the synchroniser delay. No byte is ever buffered. SCL travels only from the master side to the slave side. Ownership changes only after an SCL falling edge, or at START or STOP. This keeps SDA steady on both segments while SCL is high.

Top module: `i2crep_bridge`

## Requirements
- R1: The slave-side SCL pull-down `s_scl_oe` is 1 while master SCL is low and 0 while it is high. It follows the master SCL within three system clocks.
- R2: `m_sda_oe` and `s_sda_oe` are never both 1. The side that owns SDA is never pulled low by the block, so a low driven by one side is never echoed back to that side.
- R3: A master-side SDA fall while SCL is high, seen while the master owns SDA, is a START. It sets phase to address (`phase_o`=1), clears the bit count and makes the master the owner (`owner_o`=0). This includes a repeated START in the middle of a transfer.
- R4: A master-side SDA rise while SCL is high, seen while the master owns SDA, is a STOP. It sets phase to idle (`phase_o`=0) with the master as owner.
- R5: During the 8 bits of the address byte and of each write data byte, the master owns SDA and the slave side shows the master's level. In the 9th (acknowledge) bit the slave owns SDA (`owner_o`=1) and the master side shows the slave's level.
- R6: The 8th address bit is latched on `rw_o`. After the address acknowledge, the phase becomes write (`phase_o`=2) when it is 0 and read (`phase_o`=3) when it is 1.
- R7: During the 8 bits of a read data byte, the slave owns SDA and the master side shows its level. In the 9th bit the master owns SDA and the slave side shows the master's acknowledge level.
- R8: A not-acknowledge (high) from the master in a read, or from the slave on the address, keeps the master as owner until the next START or STOP. Lows driven by the slave in that time do not reach the master side.
- R9: `owner_o` changes only in the cycle after a synchronised SCL falling edge, START or STOP. It does not change while SCL is high.
- R10: After reset: `phase_o`=0, `owner_o`=0, `rw_o`=0, and all three pull-down outputs are 0.
- R11: While idle, the master owns SDA, and SCL toggling without a START leaves the phase idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| m_scl_i | input | 1 | SCL level sensed on the master segment |
| m_sda_i | input | 1 | SDA level sensed on the master segment |
| s_sda_i | input | 1 | SDA level sensed on the slave segment |
| m_sda_oe | output | 1 | 1 pulls master-segment SDA low |
| s_sda_oe | output | 1 | 1 pulls slave-segment SDA low |
| s_scl_oe | output | 1 | 1 pulls slave-segment SCL low |
| phase_o | output | 2 | 0 idle, 1 address, 2 write data, 3 read data |
| owner_o | output | 1 | 0 master side owns SDA, 1 slave side owns SDA |
| rw_o | output | 1 | Latched read/write bit of the last address byte |

## Verification
A table of transfers covers writes that the slave acknowledges or refuses, a read that ends with a not-acknowledge, and a read that acknowledges one byte and then refuses the next. Address and data patterns that alternate, run in blocks and mix are chosen so that a swapped owner, a wrong bit count or a late direction change shows up as a wrong level on one segment. Directed tests cover three cases. A repeated START proves the bit count is reset mid-transfer. A slave pulling low after the master's not-acknowledge proves the hold keeps that low off the master side. SCL toggling while idle proves clock edges alone cannot start a transfer.

// File: rtl/i2crep_pkg.sv
// Shared types for the I2C direction-tracking repeater.
package i2crep_pkg;
    // Transfer position decoded from the master segment
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_WRITE = 2'd2,
        PH_READ  = 2'd3
    } phase_t;

    // Segment allowed to drive SDA in the current bit
    typedef enum logic {
        OWN_MASTER = 1'b0,
        OWN_SLAVE  = 1'b1
    } owner_t;
endpackage

// File: rtl/i2crep_sync.sv
// Multi-bit flop-chain synchroniser.
// Assumes each bit is an independent slow level (SCL/SDA), so no bus coherence is needed.
module i2crep_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One register stage of the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RESET_VAL;
                else if (g == 0) chain[g] <= d_i;
                else chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2crep_tracker.sv
// Protocol tracker: finds START/STOP on the master segment, counts bits, latches R/W
// and decides which segment owns SDA for the next bit.
// Assumes synchronised inputs and one master / one slave, no clock stretching.
module i2crep_tracker
    import i2crep_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   scl_s,
    input  logic   msda_s,
    output phase_t phase_q,
    output owner_t owner_q,
    output logic   rw_q,
    output logic   scl_fall,
    output logic   start_evt,
    output logic   stop_evt
);
    localparam int ACK_IDX = BITS + 1;
    localparam int CNT_W   = $clog2(ACK_IDX + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] ACK_CNT   = CNT_W'(ACK_IDX);
    localparam logic [CNT_W-1:0] RW_PREV   = CNT_W'(BITS - 1);

    logic             scl_q, msda_q, hold_q, scl_rise;
    logic [CNT_W-1:0] cnt_q;
    phase_t           next_phase;
    owner_t           next_owner;

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & msda_q & ~msda_s & (owner_q == OWN_MASTER);
    assign stop_evt  = scl_s & scl_q & ~msda_q & msda_s & (owner_q == OWN_MASTER);

    // Phase and owner for the first bit of the byte after an acknowledge slot
    always_comb begin
        next_phase = phase_q;
        next_owner = OWN_MASTER;
        case (phase_q)
            PH_ADDR: begin
                next_phase = rw_q ? PH_READ : PH_WRITE;
                next_owner = (rw_q && !hold_q) ? OWN_SLAVE : OWN_MASTER;
            end
            PH_READ:  next_owner = hold_q ? OWN_MASTER : OWN_SLAVE;
            default:  next_owner = OWN_MASTER;
        endcase
    end

    // Edge history, bit counter, phase, R/W latch, not-acknowledge hold and owner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q   <= 1'b1;
            msda_q  <= 1'b1;
            cnt_q   <= '0;
            phase_q <= PH_IDLE;
            owner_q <= OWN_MASTER;
            rw_q    <= 1'b0;
            hold_q  <= 1'b0;
        end else begin
            scl_q  <= scl_s;
            msda_q <= msda_s;
            if (start_evt) begin
                phase_q <= PH_ADDR;
                cnt_q   <= '0;
                owner_q <= OWN_MASTER;
                hold_q  <= 1'b0;
            end else if (stop_evt) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
                owner_q <= OWN_MASTER;
                hold_q  <= 1'b0;
            end else if (phase_q != PH_IDLE) begin
                if (scl_rise) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (phase_q == PH_ADDR && cnt_q == RW_PREV) rw_q <= msda_s;
                    if ((phase_q == PH_READ || phase_q == PH_ADDR) && cnt_q == LAST_DATA)
                        hold_q <= hold_q | msda_s;
                end else if (scl_fall) begin
                    if (cnt_q == ACK_CNT) begin
                        cnt_q   <= '0;
                        phase_q <= next_phase;
                        owner_q <= next_owner;
                    end else if (cnt_q == LAST_DATA) begin
                        owner_q <= (phase_q == PH_READ) ? OWN_MASTER : OWN_SLAVE;
                    end else if (cnt_q != '0) begin
                        owner_q <= (phase_q == PH_READ && !hold_q) ? OWN_SLAVE : OWN_MASTER;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2crep_bridge.sv
// Top of the I2C direction-tracking repeater.
// Synchronises both segments, tracks the protocol and pulls the non-owning segment's
// SDA low whenever the owner's SDA is low. SCL goes master -> slave only.
// Assumes clk is many times faster than SCL and the pads are open-drain (oe=1 pulls low).
module i2crep_bridge
    import i2crep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_BITS   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       m_scl_i,
    input  logic       m_sda_i,
    input  logic       s_sda_i,
    output logic       m_sda_oe,
    output logic       s_sda_oe,
    output logic       s_scl_oe,
    output logic [1:0] phase_o,
    output logic       owner_o,
    output logic       rw_o
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] raw, synced;
    logic               scl_s, msda_s, ssda_s;
    logic               scl_fall, start_evt, stop_evt, rw_q;
    phase_t             phase_q;
    owner_t             owner_q;

    assign raw = {m_scl_i, m_sda_i, s_sda_i};
    assign {scl_s, msda_s, ssda_s} = synced;

    i2crep_sync #(
        .WIDTH    (N_LINES),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL({N_LINES{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw),
        .q_o  (synced)
    );

    i2crep_tracker #(
        .BITS(BYTE_BITS)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .msda_s   (msda_s),
        .phase_q  (phase_q),
        .owner_q  (owner_q),
        .rw_q     (rw_q),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    // Relay the owner's level onto the other segment; SCL forwarded one way
    always_comb begin
        m_sda_oe = (owner_q == OWN_SLAVE)  && !ssda_s;
        s_sda_oe = (owner_q == OWN_MASTER) && !msda_s;
        s_scl_oe = !scl_s;
    end

    assign phase_o = phase_q;
    assign owner_o = owner_q;
    assign rw_o    = rw_q;
endmodule

// File: rtl/i2crep_bridge_checker.sv
// Temporal checks for i2crep_bridge, attached by bind.
module i2crep_bridge_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       m_sda_oe,
    input logic       s_sda_oe,
    input logic [1:0] phase_o,
    input logic       owner_o,
    input logic       scl_fall,
    input logic       start_evt,
    input logic       stop_evt
);
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_sda_oe && s_sda_oe)); // R2

    AST_NO_ECHO_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_o == 1'b0) |-> !m_sda_oe); // R2

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (phase_o == 2'd1 && owner_o == 1'b0)); // R3

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (phase_o == 2'd0 && owner_o == 1'b0)); // R4

    AST_OWNER_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(owner_o) |-> $past(scl_fall || start_evt || stop_evt)); // R9

    AST_IDLE_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0) |-> (owner_o == 1'b0)); // R11
endmodule

bind i2crep_bridge i2crep_bridge_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_sda_oe (m_sda_oe),
    .s_sda_oe (s_sda_oe),
    .phase_o  (phase_o),
    .owner_o  (owner_o),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
);

// File: tb/i2crep_bridge_bench.sv
// Bench: models a master and a slave on two open-drain segments around the repeater.
module i2crep_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam int WATCHDOG   = 150000;
    // {rw, addr[6:0], data[7:0], slave_ack, master_ack}; ack 0 = acknowledge
    localparam logic [17:0] VEC [4] = '{
        {1'b0, 7'h50, 8'hA5, 1'b0, 1'b1},
        {1'b0, 7'h2B, 8'h3C, 1'b1, 1'b1},
        {1'b1, 7'h48, 8'h96, 1'b0, 1'b1},
        {1'b1, 7'h11, 8'h0F, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, mpull = 1'b0, spull = 1'b0;
    logic m_line, s_line, m_sda_oe, s_sda_oe, s_scl_oe, owner_o, rw_o, done = 1'b0;
    logic [1:0] phase_o;
    int n_cmp = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign m_line = !(mpull || m_sda_oe);
    assign s_line = !(spull || s_sda_oe);

    i2crep_bridge u_i2crep_bridge (
        .clk(clk), .rst_n(rst_n), .m_scl_i(scl), .m_sda_i(m_line), .s_sda_i(s_line),
        .m_sda_oe(m_sda_oe), .s_sda_oe(s_sda_oe), .s_scl_oe(s_scl_oe),
        .phase_o(phase_o), .owner_o(owner_o), .rw_o(rw_o)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One SCL period: drive levels while low, sample in the middle of high
    task automatic do_bit(input logic mv, input logic sv, input logic exp_m, input logic exp_s,
                          input logic exp_own, input string req);
        logic own_before;
        mpull = !mv;
        spull = !sv;
        wait_cyc(HALF);
        chk("R1", "s_scl_oe low", s_scl_oe, 1);
        scl = 1'b1;
        wait_cyc(HALF/2);
        chk(req, "master line", m_line, exp_m);
        chk(req, "slave line", s_line, exp_s);
        chk(req, "owner", owner_o, exp_own);
        chk("R1", "s_scl_oe high", s_scl_oe, 0);
        wait_cyc(HALF/2);
        own_before = owner_o;
        scl = 1'b0;
        wait_cyc(1);
        chk("R9", "owner held at fall", owner_o, own_before);
    endtask

    task automatic m_byte(input logic [7:0] b, input string req);
        for (int i = 7; i >= 0; i--) do_bit(b[i], 1'b1, b[i], b[i], 1'b0, req);
    endtask

    task automatic s_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) do_bit(1'b1, b[i], b[i], b[i], 1'b1, "R7");
    endtask

    task automatic start_idle;
        mpull = 1'b1;
        wait_cyc(HALF);
        chk("R3", "phase after START", phase_o, 1);
        chk("R3", "owner after START", owner_o, 0);
        scl = 1'b0;
        wait_cyc(1);
    endtask

    task automatic start_rep;
        mpull = 1'b0;
        spull = 1'b0;
        wait_cyc(HALF);
        scl = 1'b1;
        wait_cyc(HALF);
        mpull = 1'b1;
        wait_cyc(HALF);
        chk("R3", "phase after repeated START", phase_o, 1);
        chk("R3", "owner after repeated START", owner_o, 0);
        scl = 1'b0;
        wait_cyc(1);
    endtask

    task automatic stop_bus;
        mpull = 1'b1;
        spull = 1'b0;
        wait_cyc(HALF);
        scl = 1'b1;
        wait_cyc(HALF);
        mpull = 1'b0;
        wait_cyc(HALF);
        chk("R4", "phase after STOP", phase_o, 0);
        chk("R4", "owner after STOP", owner_o, 0);
        chk("R4", "slave line after STOP", s_line, 1);
    endtask

    task automatic addr_phase(input logic [6:0] a, input logic rw, input logic sack);
        m_byte({a, rw}, "R5");
        do_bit(1'b1, sack, sack, sack, 1'b1, "R5");
        wait_cyc(4);
        chk("R6", "rw latch", rw_o, rw);
        chk("R6", "phase after address", phase_o, rw ? 3 : 2);
    endtask

    initial begin
        wait_cyc(WATCHDOG);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);
        // R10: reset state
        chk("R10", "phase", phase_o, 0);
        chk("R10", "owner", owner_o, 0);
        chk("R10", "rw", rw_o, 0);
        chk("R10", "m_sda_oe", m_sda_oe, 0);
        chk("R10", "s_sda_oe", s_sda_oe, 0);
        chk("R10", "s_scl_oe", s_scl_oe, 0);

        // R11: SCL activity without START stays idle
        for (int k = 0; k < 3; k++) begin
            scl = 1'b0;
            wait_cyc(HALF);
            chk("R1", "idle s_scl_oe low", s_scl_oe, 1);
            scl = 1'b1;
            wait_cyc(HALF);
            chk("R11", "idle phase", phase_o, 0);
            chk("R11", "idle owner", owner_o, 0);
        end

        // Table of transfers
        for (int v = 0; v < 4; v++) begin
            logic rw, sack, mack;
            logic [6:0] a;
            logic [7:0] d;
            {rw, a, d, sack, mack} = VEC[v];
            start_idle();
            addr_phase(a, rw, 1'b0);
            if (!rw) begin
                m_byte(d, "R5");
                do_bit(1'b1, sack, sack, sack, 1'b1, "R5");
            end else begin
                s_byte(d);
                do_bit(mack, 1'b1, mack, mack, 1'b0, "R7");
                if (!mack) begin
                    s_byte(~d);
                    do_bit(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
                end
            end
            stop_bus();
        end

        // R8: after master not-acknowledge the slave cannot reach the master side
        start_idle();
        addr_phase(7'h3A, 1'b1, 1'b0);
        s_byte(8'h5C);
        do_bit(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
        wait_cyc(4);
        chk("R8", "owner after NACK", owner_o, 0);
        do_bit(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        stop_bus();

        // R3: repeated START restarts the address phase
        start_idle();
        addr_phase(7'h22, 1'b0, 1'b0);
        m_byte(8'h81, "R5");
        do_bit(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
        start_rep();
        addr_phase(7'h22, 1'b1, 1'b0);
        s_byte(8'h7E);
        do_bit(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
        stop_bus();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule